// File: doc/BRIEF.md
# Folded Benes Layer Switch

This block is one routing element in a layer of a folded Benes interconnect whose links carry traffic both ways. It has two edge-side links and two core-side links. Each link is a pair of valid/ready packet streams, one in and one out. Every packet carries a route header with a depth, a set of core-steering bits and a set of edge-steering bits. The switch reads the header and never rewrites it.

A packet that comes in from the edge is compared against the static layer number of the switch. If its depth equals that layer, the packet turns back toward the edge. Otherwise it moves on toward the core. A packet that comes in from the core always heads toward the edge. In each case the switch uses exactly one steering bit, the one at position `layer` of the relevant field, to choose between the two outputs on that side.

When two inputs want the same output, a round-robin arbiter decides. Every input has a two-entry skid buffer. Packets marked synchronised pass a barrier. A synchronised packet leaves only once both inputs of its direction hold one, so no later synchronised packet can overtake an earlier one.

Top module: `folded_benes_switch`

## Requirements
- R1: After reset, every output valid is low and every input ready is high.
- R2: A packet word is laid out from MSB to LSB as: sync flag (1 bit), depth (DW bits), core-steering field (CW bits), edge-steering field (EW bits), payload (PW bits). The steering bit used is bit number `layer` of a field. An edge-side input packet whose depth equals `layer` leaves on edge output `edge_field[layer]`.
- R3: An edge-side input packet whose depth differs from `layer` leaves on core output `core_field[layer]`.
- R4: A core-side input packet leaves on edge output `edge_field[layer]`.
- R5: Every accepted packet leaves exactly once, on one output, with all bits unchanged.
- R6: When two inputs keep requesting the same output, grants alternate between them.
- R7: An output whose valid is high while its ready is low keeps valid high and keeps its data unchanged in the next cycle.
- R8: Each input accepts two packets while its output is blocked and then drops its ready. Once the block clears, the packets leave in arrival order.
- R9: A packet with the sync flag set, coming from one input of a group, waits until the other input of the same group also holds a sync packet. The edge inputs form one group and the core inputs the other. Packets in the other group are not held back.
- R10: A second sync packet from one input does not leave before the other input of its group has supplied its own next sync packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| layer | input | DW | Static layer number of this switch |
| edge_in_valid | input | 2 | Valid for each edge-side input |
| edge_in_ready | output | 2 | Ready for each edge-side input |
| edge_in_data | input | 2*PKT | Packets from the edge side, link 0 in the low slice |
| edge_out_valid | output | 2 | Valid for each edge-side output |
| edge_out_ready | input | 2 | Ready for each edge-side output |
| edge_out_data | output | 2*PKT | Packets toward the edge side |
| core_in_valid | input | 2 | Valid for each core-side input |
| core_in_ready | output | 2 | Ready for each core-side input |
| core_in_data | input | 2*PKT | Packets from the core side |
| core_out_valid | output | 2 | Valid for each core-side output |
| core_out_ready | input | 2 | Ready for each core-side output |
| core_out_data | output | 2*PKT | Packets toward the core side |

## Verification
The bench builds the switch with DW=2, CW=3, EW=4 and PW=4, which gives a 14-bit packet. At that size it can sweep every layer from 0 to 2, every depth value and both steering-bit values on all four inputs. Within each packet the core bit and the edge bit are set to opposite values, so a switch that reads the wrong field sends the packet to the wrong output. Directed sequences then check round-robin alternation, skid-buffer filling under a blocked output, and the sync barrier with two sync packets queued behind each other.

// File: rtl/folded_benes_switch.sv
module folded_benes_switch #(
  parameter int DW = 4,
  parameter int CW = 15,
  parameter int EW = 16,
  parameter int PW = 8,
  localparam int PKT = 1 + DW + CW + EW + PW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    layer,
  input  logic [1:0]       edge_in_valid,
  output logic [1:0]       edge_in_ready,
  input  logic [2*PKT-1:0] edge_in_data,
  output logic [1:0]       edge_out_valid,
  input  logic [1:0]       edge_out_ready,
  output logic [2*PKT-1:0] edge_out_data,
  input  logic [1:0]       core_in_valid,
  output logic [1:0]       core_in_ready,
  input  logic [2*PKT-1:0] core_in_data,
  output logic [1:0]       core_out_valid,
  input  logic [1:0]       core_out_ready,
  output logic [2*PKT-1:0] core_out_data
);

  logic [3:0]          iv, ir, hv, sy, el, pop, armed;
  logic [3:0][PKT-1:0] idat, head;
  logic [3:0][1:0]     dest;
  logic [3:0][3:0]     req, gnt;
  logic [3:0][PKT-1:0] od;
  logic [3:0]          ov, ordy, fire, lk;
  logic [3:0][1:0]     widx, lid, ptr;

  assign iv   = {core_in_valid, edge_in_valid};
  assign idat = {core_in_data, edge_in_data};
  assign ordy = {core_out_ready, edge_out_ready};
  assign {core_in_ready, edge_in_ready} = ir;
  assign edge_out_valid = ov[1:0];
  assign core_out_valid = ov[3:2];
  assign edge_out_data  = {od[1], od[0]};
  assign core_out_data  = {od[3], od[2]};

  for (genvar i = 0; i < 4; i++) begin : g_in
    logic [PKT-1:0] mem [2];
    logic [1:0]     cnt;
    logic           wp, rp;
    logic [CW-1:0]  csh;
    logic [EW-1:0]  esh;
    logic           push;

    assign push = iv[i] && ir[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt <= '0;
        wp  <= 1'b0;
        rp  <= 1'b0;
      end else begin
        if (push) wp <= ~wp;
        if (pop[i]) rp <= ~rp;
        cnt <= cnt + {1'b0, push} - {1'b0, pop[i]};
      end
    end

    always_ff @(posedge clk)
      if (push) mem[wp] <= idat[i];

    assign ir[i]   = (cnt != 2'd2);
    assign hv[i]   = (cnt != 2'd0);
    assign head[i] = mem[rp];
    assign sy[i]   = head[i][PKT-1];
    assign csh     = head[i][EW+PW +: CW] >> layer;
    assign esh     = head[i][PW +: EW] >> layer;

    if (i < 2) begin : g_edge
      assign dest[i] = (head[i][PKT-2 -: DW] == layer) ? {1'b0, esh[0]} : {1'b1, csh[0]};
    end else begin : g_core
      assign dest[i] = {1'b0, esh[0]};
    end

    assign el[i] = !sy[i] || armed[i];

    p_one_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gnt[3][i], gnt[2][i], gnt[1][i], gnt[0][i]}));

    p_sync_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop[i] && sy[i]) |-> armed[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= '0;
    end else begin
      for (int g = 0; g < 2; g++) begin
        if (hv[2*g] && hv[2*g+1] && sy[2*g] && sy[2*g+1] && !armed[2*g] && !armed[2*g+1]) begin
          armed[2*g]   <= 1'b1;
          armed[2*g+1] <= 1'b1;
        end else begin
          if (pop[2*g])   armed[2*g]   <= 1'b0;
          if (pop[2*g+1]) armed[2*g+1] <= 1'b0;
        end
      end
    end
  end

  function automatic logic [3:0] rr_pick(input logic [3:0] r, input logic [1:0] p);
    logic [1:0] idx;
    rr_pick = '0;
    for (int k = 3; k >= 0; k--) begin
      idx = p + 2'(k);
      if (r[idx]) rr_pick = 4'd1 << idx;
    end
  endfunction

  always_comb begin
    pop = '0;
    for (int o = 0; o < 4; o++) begin
      for (int i = 0; i < 4; i++)
        req[o][i] = hv[i] && el[i] && (dest[i] == 2'(o));
      gnt[o]  = lk[o] ? (4'd1 << lid[o]) : rr_pick(req[o], ptr[o]);
      ov[o]   = |gnt[o];
      fire[o] = ov[o] && ordy[o];
      od[o]   = '0;
      widx[o] = '0;
      for (int i = 0; i < 4; i++) begin
        if (gnt[o][i]) begin
          od[o]   = head[i];
          widx[o] = 2'(i);
        end
        pop[i] = pop[i] | (fire[o] && gnt[o][i]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk  <= '0;
      lid <= '0;
      ptr <= '0;
    end else begin
      for (int o = 0; o < 4; o++) begin
        lk[o]  <= ov[o] && !ordy[o];
        lid[o] <= widx[o];
        if (fire[o]) ptr[o] <= widx[o] + 2'd1;
      end
    end
  end

  for (genvar o = 0; o < 4; o++) begin : g_out_chk
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ov[o] && !ordy[o]) |=> (ov[o] && od[o] == $past(od[o])));
    if (o >= 2) begin : g_core_chk
      p_no_turn_core_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ov[o] |-> (od[o][PKT-2 -: DW] != layer));
    end
  end

endmodule

// File: tb/folded_benes_switch_tb.sv
module folded_benes_switch_tb;
  localparam int DW = 2, CW = 3, EW = 4, PW = 4;
  localparam int PKT = 1 + DW + CW + EW + PW;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DW-1:0] lay = '0;
  logic [1:0] eiv = '0, eir, eov, eor = 2'b11;
  logic [1:0] civ = '0, cir, cov, cor = 2'b11;
  logic [2*PKT-1:0] eid = '0, eod, cid = '0, cod;

  int errors = 0, checks = 0, cyc = 0;
  int ocnt [4];
  logic [PKT-1:0] olog [4][64];

  always #(CLK_PERIOD/2) clk = ~clk;

  folded_benes_switch #(.DW(DW), .CW(CW), .EW(EW), .PW(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .layer(lay),
    .edge_in_valid(eiv), .edge_in_ready(eir), .edge_in_data(eid),
    .edge_out_valid(eov), .edge_out_ready(eor), .edge_out_data(eod),
    .core_in_valid(civ), .core_in_ready(cir), .core_in_data(cid),
    .core_out_valid(cov), .core_out_ready(cor), .core_out_data(cod));

  always @(negedge clk) begin
    for (int o = 0; o < 2; o++) begin
      if (eov[o] && eor[o]) begin olog[o][ocnt[o] % 64] = eod[o*PKT +: PKT]; ocnt[o]++; end
      if (cov[o] && cor[o]) begin olog[o+2][ocnt[o+2] % 64] = cod[o*PKT +: PKT]; ocnt[o+2]++; end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [PKT-1:0] mk(input bit s, input int d, input int c, input int e, input int p);
    return {s, DW'(d), CW'(c), EW'(e), PW'(p)};
  endfunction

  task automatic clr();
    for (int o = 0; o < 4; o++) ocnt[o] = 0;
  endtask

  task automatic drive(input int i, input bit v, input logic [PKT-1:0] d);
    if (i < 2) begin eiv[i] = v; eid[i*PKT +: PKT] = d; end
    else begin civ[i-2] = v; cid[(i-2)*PKT +: PKT] = d; end
  endtask

  task automatic put(input int i, input logic [PKT-1:0] d);
    drive(i, 1'b1, d);
    @(negedge clk);
    drive(i, 1'b0, '0);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  int tot;
  int exp_o;
  logic [PKT-1:0] pk;

  initial begin
    for (int o = 0; o < 4; o++) ocnt[o] = 0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(eov == 2'b00 && cov == 2'b00, "R1 out valid", int'({cov, eov}), 0);
    chk(eir == 2'b11 && cir == 2'b11, "R1 in ready", int'({cir, eir}), 15);

    for (int l = 0; l < 3; l++) begin
      lay = DW'(l);
      for (int i = 0; i < 4; i++)
        for (int d = 0; d < 4; d++)
          for (int b = 0; b < 2; b++) begin
            clr();
            pk = mk(1'b0, d, b ? (1 << l) : (7 & ~(1 << l)),
                    b ? (15 & ~(1 << l)) : (1 << l), (i * 4 + d * 2 + b) & 15);
            put(i, pk);
            idle(3);
            if (i >= 2) exp_o = 1 - b;
            else if (d == l) exp_o = 1 - b;
            else exp_o = 2 + b;
            tot = ocnt[0] + ocnt[1] + ocnt[2] + ocnt[3];
            if (i >= 2)
              chk(ocnt[exp_o] == 1, "R4 core-in port", ocnt[exp_o], 1);
            else if (d == l)
              chk(ocnt[exp_o] == 1, "R2 turnaround port", ocnt[exp_o], 1);
            else
              chk(ocnt[exp_o] == 1, "R3 toward core port", ocnt[exp_o], 1);
            chk(tot == 1 && olog[exp_o][0] == pk, "R5 exactly once unchanged",
                int'(olog[exp_o][0]), int'(pk));
          end
    end

    lay = '0;
    clr();
    drive(2, 1'b1, mk(1'b0, 0, 0, 14, 8));
    drive(3, 1'b1, mk(1'b0, 0, 0, 14, 12));
    @(negedge clk);
    drive(2, 1'b1, mk(1'b0, 0, 0, 14, 9));
    drive(3, 1'b1, mk(1'b0, 0, 0, 14, 13));
    @(negedge clk);
    drive(2, 1'b0, '0);
    drive(3, 1'b0, '0);
    idle(8);
    chk(ocnt[0] == 4, "R6 all contenders served", ocnt[0], 4);
    for (int k = 0; k < 3; k++)
      chk(olog[0][k][2] != olog[0][k+1][2], "R6 alternation",
          int'(olog[0][k+1][2]), int'(!olog[0][k][2]));

    clr();
    eor = 2'b10;
    put(2, mk(1'b0, 0, 0, 14, 1));
    put(2, mk(1'b0, 0, 0, 14, 2));
    chk(cir[0] == 1'b0, "R8 ready low when two held", int'(cir[0]), 0);
    for (int k = 0; k < 3; k++) begin
      chk(eov[0] == 1'b1 && eod[PKT-1:0] == mk(1'b0, 0, 0, 14, 1), "R7 held stable",
          int'(eod[PKT-1:0]), int'(mk(1'b0, 0, 0, 14, 1)));
      @(negedge clk);
    end
    eor = 2'b11;
    idle(4);
    chk(ocnt[0] == 2, "R8 both skid entries delivered", ocnt[0], 2);
    chk(olog[0][0][PW-1:0] == 4'd1 && olog[0][1][PW-1:0] == 4'd2, "R8 order",
        int'(olog[0][1][PW-1:0]), 2);

    clr();
    put(2, mk(1'b1, 0, 0, 14, 1));
    put(2, mk(1'b1, 0, 0, 14, 2));
    put(0, mk(1'b0, 1, 6, 0, 5));
    idle(5);
    chk(ocnt[0] + ocnt[1] == 0, "R9 lone sync waits", ocnt[0] + ocnt[1], 0);
    chk(ocnt[2] == 1, "R9 other group not held", ocnt[2], 1);
    put(3, mk(1'b1, 0, 0, 15, 3));
    idle(6);
    chk(ocnt[0] == 1 && ocnt[1] == 1, "R9 pair released", ocnt[0] + ocnt[1], 2);
    chk(olog[0][0][PW-1:0] == 4'd1, "R10 first sync only", int'(olog[0][0][PW-1:0]), 1);
    put(3, mk(1'b1, 0, 0, 15, 4));
    idle(6);
    chk(ocnt[0] == 2 && ocnt[1] == 2, "R10 second pair released", ocnt[0] + ocnt[1], 4);
    chk(olog[0][1][PW-1:0] == 4'd2, "R10 second sync order", int'(olog[0][1][PW-1:0]), 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule